// File: doc/BRIEF.md
# Shared-Counter Buffered PWM Timer

This block generates several edge-aligned pulse-width-modulated outputs from one up-counter that all channels share. The counter advances on a prescaled tick, climbs from zero to a programmable modulo value and then returns to zero, so every channel has the same period. Each channel compares the running count with its own compare value. Its output is high while the count is below that value.

Software programs the block through a single-cycle write port with combinational read data. The modulo and compare registers are double-buffered. While the counter runs, a new value waits in a shadow slot and takes effect only when the count passes from the modulo value back to zero, so the period in progress always finishes with its old settings. Reads return the value currently in effect. Software can therefore poll a register until it reads back what was written. While the counter is stopped, writes take effect at once.

Only one compare update can be pending per channel. A second compare write made before the first one has taken effect is dropped. The prescale field is locked while the counter runs. The block has no streaming data path, so every pin is a plain control or status signal.

Top module: `pwm_shared_timer`

## Requirements
- R1: A synchronous active-low reset clears every register. After reset, every readable address returns zero, `count_o` is zero and all `pwm_o` bits are low.
- R2: While running, the count advances by one on each prescaled tick from 0 to the active modulo value and then returns to 0. One period therefore lasts (modulo+1)·2^prescale clocks, and all channels share it. `count_o` shows the count.
- R3: The control register sits at address 0. Bits [1:0] hold the run mode, and a nonzero mode means the counter runs. Bits [4:2] hold the prescale value P, and the count advances once every 2^P clocks. After a start, the first advance comes 2^P clocks after the write edge.
- R4: A control write made while the counter runs updates the mode bits and leaves the prescale bits unchanged.
- R5: A modulo write (address 1) made while the counter runs is held pending and takes effect at the next wrap from modulo to 0. If several such writes arrive, the latest one wins. A readback before the wrap returns the old value.
- R6: While the counter is stopped, writes to the modulo register and to the compare registers (address 2+k for channel k) take effect immediately and read back at once.
- R7: While the counter runs and a compare update is already pending for a channel, a further compare write to that channel is ignored. After the wrap, the channel reads back and uses the first value.
- R8: A channel output is high exactly while count < compare. A compare value above the modulo value gives a constant high output, and a compare of 0 gives a constant low output.
- R9: Channel k is enabled when its 2-bit select field (address 2+NCH+k, bits [1:0]) is nonzero. A disabled channel drives its output low. A compare write made while it is disabled still stays pending and latches at the next wrap.
- R10: Setting the mode to 0 stops the counter. One clock later the count and the prescale divider are cleared, and any pending modulo or compare value is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe, sampled at the rising edge |
| addr | input | AW | Register address for reads and writes |
| wdata | input | CW | Write data |
| rdata | output | CW | Combinational read data for `addr` |
| count_o | output | CW | Current value of the shared counter |
| pwm_o | output | NCH | One PWM output per channel |

## Verification
The bench aims at the buffering boundary. It writes a new modulo value in the middle of a period and checks that the count still reaches the old limit before it adopts the new one. A design that latches at once would cut the period short. It also writes a compare register twice within one period and checks that the first value wins. A design with a simple holding register would show the second value. Other checks cover a prescale write made while running (it must not change the tick rate), a compare value left pending on a disabled channel, the flush of pending values on stop, and compare values above the modulo and at zero. In those cases an off-by-one comparison shows up as a stray one-cycle pulse.

// File: rtl/pwmt_pkg.sv
package pwmt_pkg;
  localparam int MODE_W    = 2;
  localparam int SEL_W     = 2;
  localparam int PS_W      = 3;
  localparam int MODE_LSB  = 0;
  localparam int PS_LSB    = 2;
  localparam int ADDR_CTRL = 0;
  localparam int ADDR_MOD  = 1;
  localparam int ADDR_CMP0 = 2;
endpackage

// File: rtl/pwmt_prescaler.sv
module pwmt_prescaler #(
  parameter int PS_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic [PS_W-1:0] ps,
  output logic            tick
);
  localparam int DIVW = (1 << PS_W) - 1;

  logic [DIVW-1:0] div_q;
  logic [DIVW-1:0] limit;

  assign limit = ({{(DIVW-1){1'b0}}, 1'b1} << ps) - {{(DIVW-1){1'b0}}, 1'b1};
  assign tick  = run && (div_q == limit);

  always_ff @(posedge clk) begin
    if (!rst_n || !run) div_q <= '0;
    else if (tick)      div_q <= '0;
    else                div_q <= div_q + 1'b1;
  end

  // R3: with a nonzero divide setting, ticks never come back to back
  a_r3_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && ps != '0) |=> !tick);
endmodule

// File: rtl/pwmt_counter.sv
module pwmt_counter #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          tick,
  input  logic          mod_we,
  input  logic [CW-1:0] mod_wdata,
  output logic [CW-1:0] cnt,
  output logic [CW-1:0] mod_act,
  output logic          wrap
);
  logic [CW-1:0] mod_pend;
  logic          mod_pv;

  assign wrap = run && tick && (cnt >= mod_act);

  always_ff @(posedge clk) begin
    if (!rst_n)       cnt <= '0;
    else if (!run)    cnt <= '0;
    else if (wrap)    cnt <= '0;
    else if (tick)    cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mod_act  <= '0;
      mod_pend <= '0;
      mod_pv   <= 1'b0;
    end else if (!run) begin
      if (mod_we)      mod_act <= mod_wdata;
      else if (mod_pv) mod_act <= mod_pend;
      mod_pv <= 1'b0;
    end else begin
      if (wrap && mod_pv) mod_act <= mod_pend;
      if (mod_we) begin
        mod_pend <= mod_wdata;
        mod_pv   <= 1'b1;
      end else if (wrap) begin
        mod_pv   <= 1'b0;
      end
    end
  end

  // R2: a running count never passes the active modulo value
  a_r2_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt <= mod_act));
  // R2: a wrap returns the count to zero
  a_r2_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (cnt == '0));
  // R5: the active modulo value holds between wraps while running
  a_r5_mod_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !wrap) |=> $stable(mod_act));
  // R10: a stopped counter reads zero on the next cycle
  a_r10_stop_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt == '0));
endmodule

// File: rtl/pwmt_channel.sv
module pwmt_channel #(
  parameter int CW    = 16,
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             wrap,
  input  logic             cmp_we,
  input  logic             sel_we,
  input  logic [CW-1:0]    cmp_wdata,
  input  logic [SEL_W-1:0] sel_wdata,
  input  logic [CW-1:0]    cnt,
  output logic [CW-1:0]    cmp_act,
  output logic [SEL_W-1:0] sel,
  output logic             pwm
);
  logic [CW-1:0] cmp_pend;
  logic          cmp_pv;
  logic          accept;

  // a running write is taken only if the pending slot is free (or frees now)
  assign accept = cmp_we && (!cmp_pv || wrap);

  always_ff @(posedge clk) begin
    if (!rst_n)      sel <= '0;
    else if (sel_we) sel <= sel_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp_act  <= '0;
      cmp_pend <= '0;
      cmp_pv   <= 1'b0;
    end else if (!run) begin
      if (cmp_we)      cmp_act <= cmp_wdata;
      else if (cmp_pv) cmp_act <= cmp_pend;
      cmp_pv <= 1'b0;
    end else begin
      if (wrap && cmp_pv) cmp_act <= cmp_pend;
      if (accept) begin
        cmp_pend <= cmp_wdata;
        cmp_pv   <= 1'b1;
      end else if (wrap) begin
        cmp_pv   <= 1'b0;
      end
    end
  end

  assign pwm = (sel != '0) && (cnt < cmp_act);

  // R5/R8: the active compare value holds between wraps while running
  a_r8_cmp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !wrap) |=> $stable(cmp_act));
  // R7: a second write before the latch leaves the pending value alone
  a_r7_drop_second: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cmp_pv && cmp_we && !wrap) |=> $stable(cmp_pend));
  // R9: a disabled channel keeps its pending value until the wrap
  a_r9_pend_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cmp_pv && !wrap) |=> cmp_pv);
endmodule

// File: rtl/pwm_shared_timer.sv
module pwm_shared_timer
  import pwmt_pkg::*;
#(
  parameter int NCH = 4,
  parameter int CW  = 16,
  localparam int AW = $clog2(ADDR_CMP0 + 2 * NCH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [AW-1:0]  addr,
  input  logic [CW-1:0]  wdata,
  output logic [CW-1:0]  rdata,
  output logic [CW-1:0]  count_o,
  output logic [NCH-1:0] pwm_o
);
  localparam int SEL0 = ADDR_CMP0 + NCH;

  logic [MODE_W-1:0] mode_q;
  logic [PS_W-1:0]   ps_q;
  logic              run;
  logic              tick;
  logic              wrap;
  logic              ctrl_we;
  logic              mod_we;
  logic [CW-1:0]     cnt;
  logic [CW-1:0]     mod_act;
  logic [CW-1:0]     cmp_rd [NCH];
  logic [SEL_W-1:0]  sel_rd [NCH];

  assign run     = (mode_q != '0);
  assign ctrl_we = wr_en && (addr == AW'(ADDR_CTRL));
  assign mod_we  = wr_en && (addr == AW'(ADDR_MOD));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= '0;
      ps_q   <= '0;
    end else if (ctrl_we) begin
      mode_q <= wdata[MODE_LSB +: MODE_W];
      if (!run) ps_q <= wdata[PS_LSB +: PS_W];
    end
  end

  // R4: the prescale setting cannot change while the counter runs
  a_r4_ps_locked: assert property (@(posedge clk) disable iff (!rst_n)
    run |=> $stable(ps_q));

  pwmt_prescaler #(.PS_W(PS_W)) u_presc (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (run),
    .ps   (ps_q),
    .tick (tick)
  );

  pwmt_counter #(.CW(CW)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .tick     (tick),
    .mod_we   (mod_we),
    .mod_wdata(wdata),
    .cnt      (cnt),
    .mod_act  (mod_act),
    .wrap     (wrap)
  );

  for (genvar k = 0; k < NCH; k++) begin : g_ch
    logic cmp_we_k;
    logic sel_we_k;
    assign cmp_we_k = wr_en && (addr == AW'(ADDR_CMP0 + k));
    assign sel_we_k = wr_en && (addr == AW'(SEL0 + k));

    pwmt_channel #(.CW(CW), .SEL_W(SEL_W)) u_ch (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (run),
      .wrap     (wrap),
      .cmp_we   (cmp_we_k),
      .sel_we   (sel_we_k),
      .cmp_wdata(wdata),
      .sel_wdata(wdata[SEL_W-1:0]),
      .cnt      (cnt),
      .cmp_act  (cmp_rd[k]),
      .sel      (sel_rd[k]),
      .pwm      (pwm_o[k])
    );
  end

  always_comb begin
    rdata = '0;
    if (addr == AW'(ADDR_CTRL))
      rdata = {{(CW-PS_W-MODE_W){1'b0}}, ps_q, mode_q};
    else if (addr == AW'(ADDR_MOD))
      rdata = mod_act;
    for (int k = 0; k < NCH; k++) begin
      if (addr == AW'(ADDR_CMP0 + k)) rdata = cmp_rd[k];
      if (addr == AW'(SEL0 + k))      rdata = {{(CW-SEL_W){1'b0}}, sel_rd[k]};
    end
  end

  assign count_o = cnt;
endmodule

// File: tb/pwm_shared_timer_bench.sv
module pwm_shared_timer_bench;
  localparam int CLK_P = 10;
  localparam int NCH   = 4;
  localparam int CW    = 16;
  localparam int AW    = $clog2(2 + 2 * NCH);
  localparam int A_CTRL = 0;
  localparam int A_MOD  = 1;
  localparam int A_CMP  = 2;
  localparam int A_SEL  = 2 + NCH;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           wr_en = 1'b0;
  logic [AW-1:0]  addr = '0;
  logic [CW-1:0]  wdata = '0;
  logic [CW-1:0]  rdata;
  logic [CW-1:0]  count_o;
  logic [NCH-1:0] pwm_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  pwm_shared_timer #(.NCH(NCH), .CW(CW)) u_pwm_shared_timer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .count_o(count_o), .pwm_o(pwm_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; addr = AW'(a); wdata = CW'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output int v);
    addr = AW'(a);
    #1;
    v = int'(rdata);
  endtask

  task automatic wait_count(input int c);
    for (int i = 0; i < 200; i++) begin
      if (int'(count_o) == c) break;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    int v;
    for (int a = 0; a < 2 + 2 * NCH; a++) begin
      rd(a, v);
      chk("R1 reset readback", v, 0);
    end
    chk("R1 reset count", int'(count_o), 0);
    chk("R1 reset outputs", int'(pwm_o), 0);
  endtask

  task automatic t_stopped_writes();
    int v;
    wr(A_MOD, 9);      rd(A_MOD, v);     chk("R6 modulo immediate", v, 9);
    wr(A_CMP + 0, 4);  rd(A_CMP + 0, v); chk("R6 compare immediate", v, 4);
    wr(A_CMP + 1, 100);
    wr(A_CMP + 2, 0);
    wr(A_CMP + 3, 5);
    wr(A_SEL + 0, 1);
    wr(A_SEL + 1, 2);
    wr(A_SEL + 2, 3);
    wr(A_SEL + 3, 0);
    rd(A_SEL + 1, v);  chk("R9 select readback", v, 2);
  endtask

  task automatic t_run_basic();
    wr(A_CTRL, 1);
    for (int i = 0; i < 25; i++) begin
      int e = i % 10;
      chk("R2 count sequence", int'(count_o), e);
      chk("R8 ch0 duty", int'(pwm_o[0]), (e < 4) ? 1 : 0);
      chk("R8 ch1 compare above modulo", int'(pwm_o[1]), 1);
      chk("R8 ch2 compare zero", int'(pwm_o[2]), 0);
      chk("R9 ch3 disabled low", int'(pwm_o[3]), 0);
      @(negedge clk);
    end
  endtask

  task automatic t_mod_buffer();
    int v, mx;
    wait_count(2);
    wr(A_MOD, 20);
    wr(A_MOD, 5);
    rd(A_MOD, v); chk("R5 old modulo before wrap", v, 9);
    mx = int'(count_o);
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      if (count_o == 0) break;
      if (int'(count_o) > mx) mx = int'(count_o);
    end
    chk("R5 old period completes", mx, 9);
    rd(A_MOD, v); chk("R5 latest modulo after wrap", v, 5);
    mx = 0;
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      if (count_o == 0) break;
      if (int'(count_o) > mx) mx = int'(count_o);
    end
    chk("R2 new period limit", mx, 5);
  endtask

  task automatic t_cmp_drop();
    int v;
    wait_count(0);
    wr(A_CMP + 0, 2);
    wr(A_CMP + 0, 3);
    rd(A_CMP + 0, v); chk("R7 old compare before wrap", v, 4);
    @(negedge clk);
    wait_count(0);
    rd(A_CMP + 0, v); chk("R7 first write kept", v, 2);
    for (int i = 0; i < 6; i++) begin
      chk("R8 ch0 duty after update", int'(pwm_o[0]), (int'(count_o) < 2) ? 1 : 0);
      @(negedge clk);
    end
  endtask

  task automatic t_disabled_pending();
    int v;
    wait_count(1);
    wr(A_CMP + 3, 1);
    rd(A_CMP + 3, v); chk("R9 disabled compare pending", v, 5);
    for (int i = 0; i < 8; i++) begin
      chk("R9 disabled output low", int'(pwm_o[3]), 0);
      @(negedge clk);
    end
    rd(A_CMP + 3, v); chk("R9 pending latched at wrap", v, 1);
  endtask

  task automatic t_ps_locked();
    int v, c0;
    wr(A_CTRL, (3 << 2) | 1);
    rd(A_CTRL, v); chk("R4 prescale unchanged while running", v, 1);
    for (int i = 0; i < 8; i++) begin
      c0 = int'(count_o);
      @(negedge clk);
      chk("R4 rate unchanged", int'(count_o), (c0 == 5) ? 0 : c0 + 1);
    end
  endtask

  task automatic t_stop();
    int v;
    wait_count(1);
    wr(A_CMP + 0, 3);
    wr(A_CTRL, 0);
    @(negedge clk);
    chk("R10 count cleared", int'(count_o), 0);
    rd(A_CMP + 0, v); chk("R10 pending applied on stop", v, 3);
    @(negedge clk);
    chk("R10 count stays zero", int'(count_o), 0);
  endtask

  task automatic t_prescale();
    int v;
    wr(A_CTRL, 2 << 2);
    rd(A_CTRL, v); chk("R3 prescale written while stopped", v, 8);
    wr(A_CTRL, (2 << 2) | 1);
    for (int n = 0; n < 30; n++) begin
      chk("R3 divide by four", int'(count_o), (n / 4) % 6);
      @(negedge clk);
    end
  endtask

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog (R1-R10 run) act=hung exp=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_stopped_writes();
    t_run_basic();
    t_mod_buffer();
    t_cmp_drop();
    t_disabled_pending();
    t_ps_locked();
    t_stop();
    t_prescale();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule